// File: doc/BRIEF.md
# Load/Store Address Alignment Gate

This block sits in the address-generation step of a memory-access pipeline stage. Each cycle it can take one load or store request. It adds the base register value to a sign-extended 12-bit offset at full register width to form the effective virtual address. It then decides, from the access size and a platform switch, whether the access has to trap as misaligned.

The outcome is registered, so it appears one clock after the request. An access that may proceed is handed on as a one-cycle valid pulse to the address-translation port, together with its address, direction and size. A misaligned access is never handed to translation. It produces an exception pulse instead, with a cause code and a trap value. The trap value is the untranslated effective address. When the register width is 32 bits, a doubleword request cannot be carried out, so it raises a separate size-error pulse.

Top module: `lsu_align_gate`

## Requirements
- R1: The effective address equals the base value plus the 12-bit offset sign-extended to XLEN bits, taken modulo 2^XLEN. It appears on `xlat_addr` for a forwarded access and on `exc_tval` for a trapped access.
- R2: A byte access (size code 2'b00) is never reported as misaligned.
- R3: A halfword access (size code 2'b01) with the platform switch low traps exactly when address bit 0 is 1.
- R4: A word access (size code 2'b10) with the platform switch low traps exactly when address bits [1:0] are not both zero.
- R5: With XLEN=64, a doubleword access (size code 2'b11) with the platform switch low traps exactly when address bits [2:0] are not all zero.
- R6: While `allow_misaligned` is high, no access of any size or address produces `exc_valid`.
- R7: A trapped load reports cause 4 on `exc_cause`. A trapped store reports cause 6.
- R8: An access that is not trapped is forwarded with `xlat_valid`, and `xlat_is_store` and `xlat_size` equal the request's direction and size. A trapped access never raises `xlat_valid`.
- R9: Each request with `req_valid` high produces exactly one of `xlat_valid`, `exc_valid` or `size_err`, one cycle later and for one cycle. A cycle with no request produces none of them.
- R10: With XLEN=32, a doubleword request raises only `size_err`. It is neither forwarded nor trapped, whatever its address or the platform switch.
- R11: A synchronous active-high `rst` clears `xlat_valid`, `exc_valid` and `size_err` at the next clock edge, even if a request is presented in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 = store/AMO, 0 = load |
| req_size | input | 2 | Access size: 00 byte, 01 half, 10 word, 11 double |
| base_val | input | XLEN | Base register value |
| imm_val | input | 12 | Signed address offset |
| allow_misaligned | input | 1 | Platform switch: 1 disables the alignment trap |
| xlat_valid | output | 1 | One-cycle pulse: access forwarded to translation |
| xlat_addr | output | XLEN | Effective virtual address of the forwarded access |
| xlat_is_store | output | 1 | Direction of the forwarded access |
| xlat_size | output | 2 | Size of the forwarded access |
| exc_valid | output | 1 | One-cycle pulse: misaligned-address exception |
| exc_cause | output | 4 | Exception cause code (4 load, 6 store) |
| exc_tval | output | XLEN | Faulting effective virtual address |
| size_err | output | 1 | One-cycle pulse: size not supported at this XLEN |

## Verification
The bench sweeps every size, both directions and both settings of the platform switch. It uses all eight low-address residues and offsets that carry or borrow across the low bits. It runs a 64-bit and a 32-bit instance side by side, and the base values force a wrap at bit 32 and at bit 64.

The errors it is built to catch include these:
- A checker that tested one bit too many or too few for a size would trap aligned halfwords or words, or forward misaligned ones.
- A design that swapped the load and store causes, or reported a translated or base address as the trap value, would give wrong cause or trap-value fields.
- A design whose platform switch gated only some sizes would still trap some accesses while the switch is high.
- A 32-bit build that let a doubleword through, or trapped it, would miss the size error.
- Requests issued under reset and idle gaps check that no stray pulse appears.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE   = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_DOUBLE = 2'b11
  } acc_size_e;

  localparam int unsigned CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_LOAD_MISALIGN  = 4'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_STORE_MISALIGN = 4'd6;

  // Low-address bits that must be zero for a naturally aligned access.
  function automatic logic [2:0] align_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'b000;
      SZ_HALF: return 3'b001;
      SZ_WORD: return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [CAUSE_W-1:0] misalign_cause(input logic is_store);
    return is_store ? CAUSE_STORE_MISALIGN : CAUSE_LOAD_MISALIGN;
  endfunction

endpackage

// File: rtl/lsu_ea_adder.sv
module lsu_ea_adder #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 12
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  ea_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W;

  function automatic logic [XLEN-1:0] sext_off(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] eff_addr(input logic [XLEN-1:0] b,
                                               input logic [IMM_W-1:0] o);
    return b + sext_off(o);
  endfunction

  assign ea_o = eff_addr(base_i, imm_i);
endmodule

// File: rtl/lsu_misalign_detect.sv
module lsu_misalign_detect
  import lsu_align_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [2:0] addr_low_i,
  input  logic [1:0] size_i,
  input  logic       allow_i,
  output logic       misaligned_o,
  output logic       size_illegal_o
);
  logic low_bits_set;

  generate
    if (XLEN < 64) begin : g_narrow
      assign size_illegal_o = (size_i == SZ_DOUBLE);
    end else begin : g_wide
      assign size_illegal_o = 1'b0;
    end
  endgenerate

  assign low_bits_set = |(addr_low_i & align_mask(size_i));
  assign misaligned_o = !allow_i && !size_illegal_o && low_bits_set;

  always_comb begin
    if (size_i == SZ_BYTE)
      assert_byte_clean_R2: assert (!misaligned_o);
    if (allow_i)
      assert_switch_off_R6: assert (!misaligned_o);
  end
endmodule

// File: rtl/lsu_result_stage.sv
module lsu_result_stage
  import lsu_align_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid_i,
  input  logic               is_store_i,
  input  logic [1:0]         size_i,
  input  logic [XLEN-1:0]    ea_i,
  input  logic               misaligned_i,
  input  logic               size_illegal_i,
  output logic               fwd_o,
  output logic               trap_o,
  output logic               bad_size_o,
  output logic [XLEN-1:0]    addr_o,
  output logic               is_store_o,
  output logic [1:0]         size_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic take_fwd, take_trap, take_bad;

  assign take_fwd  = req_valid_i && !misaligned_i && !size_illegal_i;
  assign take_trap = req_valid_i && misaligned_i;
  assign take_bad  = req_valid_i && size_illegal_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_o      <= 1'b0;
      trap_o     <= 1'b0;
      bad_size_o <= 1'b0;
    end else begin
      fwd_o      <= take_fwd;
      trap_o     <= take_trap;
      bad_size_o <= take_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid_i) begin
      addr_o     <= ea_i;
      is_store_o <= is_store_i;
      size_o     <= size_i;
      cause_o    <= misalign_cause(is_store_i);
    end
  end
endmodule

// File: rtl/lsu_align_gate.sv
module lsu_align_gate
  import lsu_align_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_is_store,
  input  logic [1:0]         req_size,
  input  logic [XLEN-1:0]    base_val,
  input  logic [IMM_W-1:0]   imm_val,
  input  logic               allow_misaligned,
  output logic               xlat_valid,
  output logic [XLEN-1:0]    xlat_addr,
  output logic               xlat_is_store,
  output logic [1:0]         xlat_size,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [XLEN-1:0]    exc_tval,
  output logic               size_err
);
  logic [XLEN-1:0] ea_w;
  logic            misaligned_w;
  logic            size_illegal_w;
  logic [XLEN-1:0] addr_q;

  lsu_ea_adder #(.XLEN(XLEN), .IMM_W(IMM_W)) u_adder (
    .base_i (base_val),
    .imm_i  (imm_val),
    .ea_o   (ea_w)
  );

  lsu_misalign_detect #(.XLEN(XLEN)) u_detect (
    .addr_low_i     (ea_w[2:0]),
    .size_i         (req_size),
    .allow_i        (allow_misaligned),
    .misaligned_o   (misaligned_w),
    .size_illegal_o (size_illegal_w)
  );

  lsu_result_stage #(.XLEN(XLEN)) u_stage (
    .clk            (clk),
    .rst            (rst),
    .req_valid_i    (req_valid),
    .is_store_i     (req_is_store),
    .size_i         (req_size),
    .ea_i           (ea_w),
    .misaligned_i   (misaligned_w),
    .size_illegal_i (size_illegal_w),
    .fwd_o          (xlat_valid),
    .trap_o         (exc_valid),
    .bad_size_o     (size_err),
    .addr_o         (addr_q),
    .is_store_o     (xlat_is_store),
    .size_o         (xlat_size),
    .cause_o        (exc_cause)
  );

  assign xlat_addr = addr_q;
  assign exc_tval  = addr_q;

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ($countones({xlat_valid, exc_valid, size_err}) == 1));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(xlat_valid || exc_valid || size_err));

  assert_switch_no_trap_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && allow_misaligned) |=> !exc_valid);

  assert_cause_dir_R7: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_cause == ($past(req_is_store) ? 4'd6 : 4'd4)));

  assert_tval_is_ea_R1: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_tval == $past(ea_w)));

  assert_half_odd_traps_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !allow_misaligned && req_size == SZ_HALF && ea_w[0]) |=> exc_valid);

  assert_trap_not_fwd_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && misaligned_w) |=> !xlat_valid);
endmodule

// File: tb/sim_lsu_align_gate.sv
`timescale 1ns/1ps
module sim_lsu_align_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_is_store = 1'b0, allow = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [63:0] base = '0;
  logic [11:0] imm = '0;

  logic        xv0, ev0, se0, xs0;
  logic [1:0]  xz0;
  logic [3:0]  ec0;
  logic [63:0] xa0, tv0;
  logic        xv1, ev1, se1, xs1;
  logic [1:0]  xz1;
  logic [3:0]  ec1;
  logic [31:0] xa1, tv1;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lsu_align_gate #(.XLEN(64)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_store(req_is_store),
    .req_size(req_size), .base_val(base), .imm_val(imm), .allow_misaligned(allow),
    .xlat_valid(xv0), .xlat_addr(xa0), .xlat_is_store(xs0), .xlat_size(xz0),
    .exc_valid(ev0), .exc_cause(ec0), .exc_tval(tv0), .size_err(se0));

  lsu_align_gate #(.XLEN(32)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_store(req_is_store),
    .req_size(req_size), .base_val(base[31:0]), .imm_val(imm), .allow_misaligned(allow),
    .xlat_valid(xv1), .xlat_addr(xa1), .xlat_is_store(xs1), .xlat_size(xz1),
    .exc_valid(ev1), .exc_cause(ec1), .exc_tval(tv1), .size_err(se1));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet(input string req);
    chk(!(xv0 || ev0 || se0), req, {61'd0, xv0, ev0, se0}, 64'd0);
    chk(!(xv1 || ev1 || se1), req, {61'd0, xv1, ev1, se1}, 64'd0);
  endtask

  task automatic one_req(input bit st, input logic [1:0] sz, input logic [63:0] b,
                         input logic [11:0] im, input bit ok);
    logic [63:0] ea64;
    logic [31:0] ea32;
    longint unsigned gran;
    bit mis64, mis32, big32;
    @(negedge clk);
    req_valid = 1'b1; req_is_store = st; req_size = sz; base = b; imm = im; allow = ok;
    ea64 = b + {{52{im[11]}}, im};
    ea32 = b[31:0] + {{20{im[11]}}, im};
    gran = 64'd1 << sz;
    mis64 = !ok && ((ea64 % gran) != 0);
    big32 = (sz == 2'b11);
    mis32 = !ok && !big32 && ((ea32 % gran) != 0);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    // 64-bit instance
    chk((xv0 + ev0 + se0) == 1, "R9", {61'd0, xv0, ev0, se0}, 64'd1);
    if (mis64) begin
      chk(ev0, sz == 2'b00 ? "R2" : sz == 2'b01 ? "R3" : sz == 2'b10 ? "R4" : "R5", ev0, 1);
      chk(!xv0, "R8", xv0, 0);
      chk(ec0 == (st ? 4'd6 : 4'd4), "R7", ec0, st ? 6 : 4);
      chk(tv0 == ea64, "R1", tv0, ea64);
    end else begin
      chk(!ev0, ok ? "R6" : sz == 2'b00 ? "R2" : sz == 2'b01 ? "R3" : sz == 2'b10 ? "R4" : "R5", ev0, 0);
      chk(xv0 && xs0 == st && xz0 == sz, "R8", {xv0, xs0, xz0}, {1'b1, st, sz});
      chk(xa0 == ea64, "R1", xa0, ea64);
    end
    // 32-bit instance
    if (big32) begin
      chk(se1 && !xv1 && !ev1, "R10", {61'd0, xv1, ev1, se1}, 64'd1);
    end else if (mis32) begin
      chk(ev1 && !xv1 && !se1, "R4", {61'd0, xv1, ev1, se1}, 64'd2);
      chk(ec1 == (st ? 4'd6 : 4'd4), "R7", ec1, st ? 6 : 4);
      chk(tv1 == ea32, "R1", tv1, ea32);
    end else begin
      chk(xv1 && !ev1 && !se1, "R8", {61'd0, xv1, ev1, se1}, 64'd4);
      chk(xa1 == ea32, "R1", xa1, ea32);
    end
  endtask

  initial begin
    logic [11:0] offs [7];
    logic [63:0] bases [3];
    offs[0] = 12'h000; offs[1] = 12'h001; offs[2] = 12'hFFF; offs[3] = 12'h005;
    offs[4] = 12'hFF8; offs[5] = 12'h7FF; offs[6] = 12'h800;
    bases[0] = 64'h0000_0000_FFFF_FFF8; bases[1] = 64'hFFFF_FFFF_FFFF_FFF8;
    bases[2] = 64'h1234_5678_9ABC_DE00;
    repeat (3) @(posedge clk);
    #1;
    quiet("R11");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    quiet("R9");
    for (int ok = 0; ok < 2; ok++)
      for (int st = 0; st < 2; st++)
        for (int sz = 0; sz < 4; sz++)
          for (int bi = 0; bi < 3; bi++)
            for (int lo = 0; lo < 8; lo++)
              for (int oi = 0; oi < 7; oi++)
                one_req(st[0], sz[1:0], bases[bi] | 64'(lo), offs[oi], ok[0]);
    // idle gap: no request, no pulse
    @(negedge clk);
    @(posedge clk); #1;
    quiet("R9");
    // request presented while reset is asserted: must be dropped
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b1; req_size = 2'b01; base = 64'd1; imm = '0; allow = 1'b0;
    @(posedge clk); #1;
    quiet("R11");
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b0;
    @(posedge clk); #1;
    quiet("R11");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule